// File: doc/BRIEF.md
# Write-Update Snoopy Line Controller

This block keeps one cache line coherent under a write-broadcast protocol. A write to a line that other caches may also hold does not invalidate their copies. The writer places the merged word on the bus, and every other holder takes it in. Memory is never written through. While a dirty line is shared, exactly one cache owns it and answers snooped reads on its behalf. A line that is present is always in one of four coherent states. Whether the line is present at all is kept in a separate presence bit.

The processor side raises read, write or evict and holds the request until `cpu_done` pulses. Writes carry byte enables. The bus side issues a fetch (`bus_rd`) or an update broadcast (`bus_upd`). Each of these is a one-cycle transaction: the wired shared line and the fill word are sampled in that same cycle. Snooped reads and snooped updates from other caches are answered in the cycle they arrive. The answer can raise the shared line, drive the word with a supply strobe, or merge the broadcast word. The data array, arbitration and memory sit outside the block. The line word is held in a register inside the block.

Top module: `wupd_line_ctrl`

## Requirements
- R1: After reset the line is absent (`line_present`=0) and `bus_rd`, `bus_upd`, `supply`, `copyback`, `shared_out` and `cpu_done` are low. At most one of `bus_rd`, `bus_upd`, `supply` and `copyback` is high in any cycle.
- R2: A read on an absent line completes in two cycles. `bus_rd` is high in the second cycle, and `cpu_rdata` returns `bus_fill_data` together with `cpu_done`. The line then holds the fill word in state 0 (shared-clean) if `bus_shared_in` was high in that cycle, otherwise in state 1 (valid-exclusive). The state encoding is shared-clean=0, valid-exclusive=1, shared-dirty=2, dirty=3.
- R3: A write hit in state 3 or 1 completes in one cycle with no bus activity. The enabled bytes are merged into the word (`cpu_be` bit i covers bits 8i+7:8i), and the state becomes 3.
- R4: A write hit in state 2 or 0 merges locally, then in the next cycle drives `bus_upd` with the merged word on `bus_data` and completes. The line ends in state 2 if `bus_shared_in` is high in that cycle, otherwise in state 3. No copy-back occurs.
- R5: A write on an absent line first fetches as in R2 and merges the bytes into the fill word. If the shared line was low during the fetch, it completes there in state 3 with no broadcast. Otherwise it broadcasts as in R4 in a third cycle.
- R6: A snooped read on a present line in state 3 or 2 raises `shared_out` and `supply` in the same cycle, with the line word on `bus_data`, and leaves the line in state 2.
- R7: A snooped read on a present line in state 1 or 0 raises `shared_out` without `supply` and leaves the line in state 0 with its word unchanged.
- R8: A snooped update on a present line raises `shared_out`, merges `snp_data` under `snp_be` into the word, and leaves the line in state 0.
- R9: Snoops on an absent line raise no output, and the line stays absent.
- R10: An evict completes in one cycle and clears presence. `copyback` pulses with the word on `bus_data` only when the line was present in state 3 or 2.
- R11: In a cycle with a snoop strobe the pending processor request does not complete.
- R12: A read hit completes in one cycle with the line word on `cpu_rdata`, no bus activity and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read request, held until done |
| cpu_wr | input | 1 | Processor write request, held until done |
| cpu_evict | input | 1 | Processor evict request |
| cpu_wdata | input | DATA_W | Write word |
| cpu_be | input | DATA_W/8 | Write byte enables |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with done |
| snp_rd | input | 1 | Snooped read from another cache |
| snp_upd | input | 1 | Snooped update broadcast |
| snp_data | input | DATA_W | Broadcast word |
| snp_be | input | DATA_W/8 | Broadcast byte enables |
| bus_rd | output | 1 | Fetch command on the bus |
| bus_upd | output | 1 | Update broadcast command |
| bus_fill_data | input | DATA_W | Fill word during a fetch |
| bus_shared_in | input | 1 | Wired shared line, sampled in own transaction |
| bus_data | output | DATA_W | Word driven for update, supply or copy-back |
| supply | output | 1 | This cache supplies a snooped read |
| shared_out | output | 1 | Snoop hit, assert shared line |
| copyback | output | 1 | Dirty word written back on evict |
| line_present | output | 1 | Presence bit |
| line_state | output | 2 | Coherent state (0 SC, 1 VE, 2 SD, 3 D) |

## Verification
A wrong coherent state shows up at the ports at the next operation on the line. A stale owner state would make the next snooped read raise `supply` when it should not. A clean state that should be dirty would lose the `copyback` at evict. A shared state that should be exclusive would add a `bus_upd` cycle to the next write. The bench reaches each of the four states and applies every processor and snoop operation with both shared-line levels. It compares strobes, cycle counts and the merged word against a model built from the requirements, so any such error surfaces within one or two cycles of the operation that exposes it.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
    typedef enum logic [1:0] {
        ST_SC = 2'd0,
        ST_VE = 2'd1,
        ST_SD = 2'd2,
        ST_D  = 2'd3
    } cstate_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FETCH  = 2'd1,
        PH_UPDATE = 2'd2
    } phase_e;

    function automatic logic is_owner(cstate_e s);
        return (s == ST_D) || (s == ST_SD);
    endfunction
endpackage

// File: rtl/wupd_byte_merge.sv
module wupd_byte_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]     old_word,
    input  logic [DATA_W-1:0]     new_word,
    input  logic [DATA_W/8-1:0]   byte_en,
    output logic [DATA_W-1:0]     merged
);
    localparam int BYTES = DATA_W / 8;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = byte_en[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
    end
endmodule

// File: rtl/wupd_snoop_resp.sv
module wupd_snoop_resp
    import wupd_pkg::*;
(
    input  logic    active,
    input  logic    present,
    input  cstate_e st,
    input  logic    snp_rd,
    input  logic    snp_upd,
    output logic    hit,
    output logic    do_supply,
    output logic    take_word,
    output cstate_e st_next
);
    always_comb begin
        hit       = active && present && (snp_rd || snp_upd);
        do_supply = hit && snp_rd && !snp_upd && is_owner(st);
        take_word = hit && snp_upd;
        if (!hit)
            st_next = st;
        else if (snp_upd)
            st_next = ST_SC;
        else if (is_owner(st))
            st_next = ST_SD;
        else
            st_next = ST_SC;
    end
endmodule

// File: rtl/wupd_line_ctrl.sv
module wupd_line_ctrl
    import wupd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic                  cpu_evict,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [DATA_W/8-1:0]   cpu_be,
    output logic                  cpu_done,
    output logic [DATA_W-1:0]     cpu_rdata,
    input  logic                  snp_rd,
    input  logic                  snp_upd,
    input  logic [DATA_W-1:0]     snp_data,
    input  logic [DATA_W/8-1:0]   snp_be,
    output logic                  bus_rd,
    output logic                  bus_upd,
    input  logic [DATA_W-1:0]     bus_fill_data,
    input  logic                  bus_shared_in,
    output logic [DATA_W-1:0]     bus_data,
    output logic                  supply,
    output logic                  shared_out,
    output logic                  copyback,
    output logic                  line_present,
    output logic [1:0]            line_state
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic              present;
        cstate_e           st;
        phase_e            ph;
        logic [DATA_W-1:0] word;
    } regs_t;

    regs_t r_q, r_d;

    logic [DATA_W-1:0] m_hit, m_fill, m_snp;
    logic              snp_hit, snp_supply, snp_take;
    cstate_e           snp_st_next;
    logic              idle;
    logic              any_snoop;

    assign idle      = (r_q.ph == PH_IDLE);
    assign any_snoop = snp_rd || snp_upd;

    wupd_byte_merge #(.DATA_W(DATA_W)) u_merge_hit (
        .old_word(r_q.word), .new_word(cpu_wdata), .byte_en(cpu_be), .merged(m_hit));
    wupd_byte_merge #(.DATA_W(DATA_W)) u_merge_fill (
        .old_word(bus_fill_data), .new_word(cpu_wdata), .byte_en(cpu_be), .merged(m_fill));
    wupd_byte_merge #(.DATA_W(DATA_W)) u_merge_snp (
        .old_word(r_q.word), .new_word(snp_data), .byte_en(snp_be), .merged(m_snp));

    wupd_snoop_resp u_snoop (
        .active   (idle),
        .present  (r_q.present),
        .st       (r_q.st),
        .snp_rd   (snp_rd),
        .snp_upd  (snp_upd),
        .hit      (snp_hit),
        .do_supply(snp_supply),
        .take_word(snp_take),
        .st_next  (snp_st_next)
    );

    always_comb begin
        r_d        = r_q;
        cpu_done   = 1'b0;
        cpu_rdata  = r_q.word;
        bus_rd     = 1'b0;
        bus_upd    = 1'b0;
        bus_data   = '0;
        supply     = 1'b0;
        shared_out = 1'b0;
        copyback   = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (any_snoop) begin
                    shared_out = snp_hit;
                    supply     = snp_supply;
                    if (snp_supply)
                        bus_data = r_q.word;
                    if (snp_take)
                        r_d.word = m_snp;
                    r_d.st = snp_st_next;
                end else if (cpu_rd) begin
                    if (r_q.present)
                        cpu_done = 1'b1;
                    else
                        r_d.ph = PH_FETCH;
                end else if (cpu_wr) begin
                    if (!r_q.present) begin
                        r_d.ph = PH_FETCH;
                    end else if (r_q.st == ST_D || r_q.st == ST_VE) begin
                        r_d.word = m_hit;
                        r_d.st   = ST_D;
                        cpu_done = 1'b1;
                    end else begin
                        r_d.word = m_hit;
                        r_d.ph   = PH_UPDATE;
                    end
                end else if (cpu_evict) begin
                    cpu_done = 1'b1;
                    if (r_q.present && is_owner(r_q.st)) begin
                        copyback = 1'b1;
                        bus_data = r_q.word;
                    end
                    r_d.present = 1'b0;
                end
            end
            PH_FETCH: begin
                bus_rd      = 1'b1;
                cpu_rdata   = bus_fill_data;
                r_d.present = 1'b1;
                if (cpu_wr) begin
                    r_d.word = m_fill;
                    if (bus_shared_in) begin
                        r_d.st = ST_SD;
                        r_d.ph = PH_UPDATE;
                    end else begin
                        r_d.st   = ST_D;
                        r_d.ph   = PH_IDLE;
                        cpu_done = 1'b1;
                    end
                end else begin
                    r_d.word = bus_fill_data;
                    r_d.st   = bus_shared_in ? ST_SC : ST_VE;
                    r_d.ph   = PH_IDLE;
                    cpu_done = 1'b1;
                end
            end
            PH_UPDATE: begin
                bus_upd  = 1'b1;
                bus_data = r_q.word;
                r_d.st   = bus_shared_in ? ST_SD : ST_D;
                r_d.ph   = PH_IDLE;
                cpu_done = 1'b1;
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.present <= 1'b0;
            r_q.st      <= ST_SC;
            r_q.ph      <= PH_IDLE;
            r_q.word    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_present = r_q.present;
    assign line_state   = r_q.st;

    a_r1_one_bus_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_upd, supply, copyback}));

    a_r2_fetch_only_absent: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !line_present);

    a_r4_update_leaves_owner: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd |=> (line_present && (line_state == ST_D || line_state == ST_SD)));

    a_r6_supply_from_owner: assert property (@(posedge clk) disable iff (!rst_n)
        supply |-> (line_present && shared_out && (line_state == ST_D || line_state == ST_SD)));

    a_r6_supply_ends_sd: assert property (@(posedge clk) disable iff (!rst_n)
        supply |=> (line_state == ST_SD));

    a_r8_update_ends_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && line_present && snp_upd) |=> (line_state == ST_SC));

    a_r9_absent_snoop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !line_present && any_snoop) |-> (!shared_out && !supply));

    a_r10_copyback_clears: assert property (@(posedge clk) disable iff (!rst_n)
        copyback |=> !line_present);

    a_r11_snoop_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && any_snoop) |-> !cpu_done);

    localparam int UNUSED_BE_W = BE_W;
endmodule

// File: tb/wupd_line_ctrl_test.sv
`timescale 1ns/1ps
module wupd_line_ctrl_test;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_rd = 0, cpu_wr = 0, cpu_evict = 0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [BW-1:0] cpu_be = '0;
    logic cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic snp_rd = 0, snp_upd = 0;
    logic [DW-1:0] snp_data = '0;
    logic [BW-1:0] snp_be = '0;
    logic bus_rd, bus_upd;
    logic [DW-1:0] bus_fill_data = '0;
    logic bus_shared_in = 0;
    logic [DW-1:0] bus_data;
    logic supply, shared_out, copyback, line_present;
    logic [1:0] line_state;

    always #10 clk = ~clk;

    wupd_line_ctrl #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_evict(cpu_evict),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .snp_rd(snp_rd), .snp_upd(snp_upd), .snp_data(snp_data), .snp_be(snp_be),
        .bus_rd(bus_rd), .bus_upd(bus_upd), .bus_fill_data(bus_fill_data),
        .bus_shared_in(bus_shared_in), .bus_data(bus_data),
        .supply(supply), .shared_out(shared_out), .copyback(copyback),
        .line_present(line_present), .line_state(line_state)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // model of the line, kept from the requirements
    logic          m_present;
    logic [1:0]    m_st;
    logic [DW-1:0] m_word;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [BW-1:0] be);
        logic [DW-1:0] r = o;
        for (int b = 0; b < BW; b++)
            if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    function automatic bit owner(input logic [1:0] s);
        return s == 2'd3 || s == 2'd2;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        cpu_rd = 0; cpu_wr = 0; cpu_evict = 0; snp_rd = 0; snp_upd = 0; bus_shared_in = 0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(line_present == 0, "R1 present after reset", DW'(line_present), 0);
        chk({bus_rd, bus_upd, supply, copyback, shared_out, cpu_done} == 6'b0, "R1 strobes after reset",
            DW'({bus_rd, bus_upd, supply, copyback, shared_out, cpu_done}), 0);
        rst_n = 1;
        m_present = 0; m_st = 2'd0; m_word = '0;
    endtask

    task automatic check_line(input string req);
        #1;
        chk(line_present == m_present, {req, " presence"}, DW'(line_present), DW'(m_present));
        if (m_present)
            chk(line_state == m_st, {req, " state"}, DW'(line_state), DW'(m_st));
    endtask

    // kind: 0 read, 1 write, 2 evict
    task automatic do_cpu(input int kind, input logic [DW-1:0] wd, input logic [BW-1:0] be,
                          input logic [DW-1:0] fill, input bit shf, input bit shu, input string req);
        int e_cyc; bit e_rd, e_upd, e_cb; logic [DW-1:0] e_bus, e_rdata;
        int g_cyc; bit g_rd, g_upd, g_cb; logic [DW-1:0] g_bus, g_rdata;
        bit fin;
        e_rd = 0; e_upd = 0; e_cb = 0; e_bus = '0; e_rdata = m_word; e_cyc = 1;
        case (kind)
            0: if (!m_present) begin
                   e_cyc = 2; e_rd = 1; e_rdata = fill;
                   m_present = 1; m_word = fill; m_st = shf ? 2'd0 : 2'd1;
               end
            1: if (!m_present) begin
                   e_rd = 1; m_present = 1; m_word = merge(fill, wd, be);
                   if (shf) begin e_cyc = 3; e_upd = 1; e_bus = m_word; m_st = shu ? 2'd2 : 2'd3; end
                   else begin e_cyc = 2; m_st = 2'd3; end
               end else if (m_st == 2'd3 || m_st == 2'd1) begin
                   m_word = merge(m_word, wd, be); m_st = 2'd3;
               end else begin
                   m_word = merge(m_word, wd, be); e_cyc = 2; e_upd = 1; e_bus = m_word;
                   m_st = shu ? 2'd2 : 2'd3;
               end
            default: begin
                if (m_present && owner(m_st)) begin e_cb = 1; e_bus = m_word; end
                m_present = 0;
            end
        endcase
        g_rd = 0; g_upd = 0; g_cb = 0; g_bus = '0; g_rdata = '0; g_cyc = 0; fin = 0;
        @(negedge clk);
        cpu_rd = (kind == 0); cpu_wr = (kind == 1); cpu_evict = (kind == 2);
        cpu_wdata = wd; cpu_be = be;
        for (int c = 1; c <= 4 && !fin; c++) begin
            #1;
            bus_shared_in = 0;
            if (bus_rd) begin g_rd = 1; bus_fill_data = fill; bus_shared_in = shf; end
            if (bus_upd) begin g_upd = 1; bus_shared_in = shu; end
            #4;
            if (bus_upd) g_bus = bus_data;
            if (copyback) begin g_cb = 1; g_bus = bus_data; end
            if (cpu_done) begin fin = 1; g_cyc = c; g_rdata = cpu_rdata; end
            @(negedge clk);
        end
        cpu_rd = 0; cpu_wr = 0; cpu_evict = 0; bus_shared_in = 0;
        chk(g_cyc == e_cyc, {req, " completion cycle"}, DW'(g_cyc), DW'(e_cyc));
        chk(g_rd == e_rd, {req, " fetch command"}, DW'(g_rd), DW'(e_rd));
        chk(g_upd == e_upd, {req, " update broadcast"}, DW'(g_upd), DW'(e_upd));
        chk(g_cb == e_cb, {req, " copy-back"}, DW'(g_cb), DW'(e_cb));
        if (e_upd || e_cb)
            chk(g_bus == e_bus, {req, " bus word"}, g_bus, e_bus);
        if (kind == 0)
            chk(g_rdata == e_rdata, {req, " read word"}, g_rdata, e_rdata);
        check_line(req);
    endtask

    // reads the word back through a read hit (R12) and compares with the model
    task automatic check_word(input string req);
        if (m_present) do_cpu(0, '0, '0, '0, 0, 0, {req, " R12 readback"});
    endtask

    task automatic do_snoop(input bit rd, input bit upd, input logic [DW-1:0] sd,
                            input logic [BW-1:0] sbe, input bit with_cpu, input string req);
        bit e_sh, e_sup; logic [DW-1:0] e_bus;
        e_sh = m_present; e_sup = m_present && rd && owner(m_st); e_bus = m_word;
        if (m_present) begin
            if (upd) begin m_word = merge(m_word, sd, sbe); m_st = 2'd0; end
            else m_st = owner(m_st) ? 2'd2 : 2'd0;
        end
        @(negedge clk);
        snp_rd = rd; snp_upd = upd; snp_data = sd; snp_be = sbe;
        cpu_rd = with_cpu;
        #5;
        chk(shared_out == e_sh, {req, " shared_out"}, DW'(shared_out), DW'(e_sh));
        chk(supply == e_sup, {req, " supply"}, DW'(supply), DW'(e_sup));
        if (e_sup) chk(bus_data == e_bus, {req, " supplied word"}, bus_data, e_bus);
        if (with_cpu) chk(cpu_done == 0, "R11 no done during snoop", DW'(cpu_done), 0);
        @(negedge clk);
        snp_rd = 0; snp_upd = 0; cpu_rd = 0;
        check_line(req);
    endtask

    task automatic reach(input int s);
        do_reset();
        case (s)
            0: do_cpu(0, '0, '0, 32'h5C5C_0000, 1, 0, "R2 reach SC");
            1: do_cpu(0, '0, '0, 32'h1E1E_0001, 0, 0, "R2 reach VE");
            2: begin
                do_cpu(0, '0, '0, 32'h5D5D_0002, 1, 0, "R2 reach SC for SD");
                do_cpu(1, 32'hAB00_00CD, 4'b1001, '0, 1, 1, "R4 reach SD");
            end
            default: do_cpu(1, 32'h0D0D_0D0D, 4'b0110, 32'hD000_0003, 0, 0, "R5 reach D");
        endcase
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // R9: absent line ignores snoops, later fill is not polluted
        do_reset();
        do_snoop(1, 0, 32'hFFFF_FFFF, 4'hF, 0, "R9 absent snoop read");
        do_snoop(0, 1, 32'hFFFF_FFFF, 4'hF, 0, "R9 absent snoop update");
        do_cpu(0, '0, '0, 32'h1234_5678, 0, 0, "R2 miss after absent snoops");
        check_word("R9");
        do_cpu(2, '0, '0, '0, 0, 0, "R10 evict clean");
        do_snoop(0, 1, 32'hEEEE_EEEE, 4'hF, 0, "R9 snoop after evict");
        do_cpu(2, '0, '0, '0, 0, 0, "R10 evict absent");

        // sweep: every start state, every operation, both shared levels
        for (int s = 0; s < 4; s++)
            for (int op = 0; op < 5; op++)
                for (int sh = 0; sh < 2; sh++) begin
                    logic [DW-1:0] wd;
                    logic [BW-1:0] be;
                    wd = 32'hA500_0000 ^ DW'(s << 12) ^ DW'(op << 8) ^ DW'(sh << 4) ^ 32'h0000_0C03;
                    be = BW'(s + op + 2 * sh + 1);
                    reach(s);
                    case (op)
                        0: do_cpu(0, '0, '0, '0, sh[0], 0, "R12 read hit sweep");
                        1: do_cpu(1, wd, be, '0, sh[0], sh[0], "R3 R4 write hit sweep");
                        2: do_cpu(2, '0, '0, '0, 0, 0, "R10 evict sweep");
                        3: do_snoop(1, 0, '0, '0, 0, "R6 R7 snoop read sweep");
                        default: do_snoop(0, 1, wd, be, 0, "R8 snoop update sweep");
                    endcase
                    check_word("sweep");
                    // follow-up evict exposes ownership left behind
                    do_cpu(2, '0, '0, '0, 0, 0, "R10 follow-up evict");
                end

        // R5: write miss with shared fetch then lone update, and all four combinations
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++) begin
                do_reset();
                do_cpu(1, 32'hCAFE_F00D, 4'b1010, 32'h0102_0304, a[0], b[0], "R5 write miss");
                check_word("R5");
            end

        // R11: snoop wins over a pending read hit
        reach(3);
        do_snoop(1, 0, '0, '0, 1, "R11 snoop with pending read");
        reach(1);
        do_snoop(0, 1, 32'h7777_8888, 4'b0011, 1, "R11 snoop update with pending read");
        check_word("R11");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule